// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Per-Bank Row Tracking

This block sits on the device side of a four-bank DDR SDRAM and interprets the command pins sampled on every rising clock edge. It sorts chip select and the three active-low row, column and write strobes into one of seven commands. It validates each command against the open or closed state it keeps for every bank, and publishes one registered result per accepted command: the command code, the bank, the row or column address, and the auto-precharge and all-bank flags.

The tracker remembers the row opened in each bank. A read or write therefore reports the row it lands in as well as its column. Address bit 10 has two jobs: with a read or write it requests a precharge once the access is over, and with a precharge it widens the command to every bank. An auto-precharged bank stays busy for a programmable number of cycles and then becomes free to activate again.

Clock enable is handled at the command level. A low sample suspends the next cycle. A refresh issued with clock enable low enters self refresh, which lasts until clock enable is sampled high again. Commands that break the bank rules are not carried out and raise an error pulse instead.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When `cs_n` is high at a rising edge, that edge produces no command: `cmd_valid` and `illegal` are both low after it, and no bank state changes.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` selects the command: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 111 and 110 no operation. An accepted command drives `cmd_valid` high for the one cycle following its edge, with `cmd_code` equal to the three strobe bits. For a mode set, `cmd_row` carries `addr`.
- R3: An activate to a closed bank is accepted with `cmd_bank` = `ba` and `cmd_row` = `addr`, and it opens that bank on that row. An activate to a bank that is already open is illegal.
- R4: A read or write to an open, idle bank is accepted with `cmd_col` = `addr[8:0]` and `cmd_row` = the row stored for that bank. A read or write to a closed bank is illegal.
- R5: `auto_pre` equals `addr[10]` on an accepted read or write. If the access is made at edge N, then reads and writes to that bank are illegal from edge N+1, activates to it stay illegal through edge N+AP_DELAY-1, and an activate at edge N+AP_DELAY or later is accepted.
- R6: An accepted precharge with `addr[10]` high sets `all_banks` and closes every bank. With `addr[10]` low it closes only bank `ba`, and the other banks keep their rows.
- R7: An illegal command raises `illegal` for one cycle with `cmd_valid` low, and it leaves the bank state unchanged.
- R8: When `cke` is sampled low at an edge, the command at the following edge is ignored: no `cmd_valid`, no `illegal`, no state change.
- R9: A refresh accepted at an edge where `cke` is low enters self refresh. After that edge `self_ref` is high and the refresh is reported with `cmd_valid` and code 001.
- R10: While `self_ref` is high, every command is ignored. `self_ref` stays high while `cke` is sampled low and clears at the first edge with `cke` high, and the command at that edge is ignored too.
- R11: Synchronous reset clears every output, closes all banks, leaves self refresh and marks the next edge as not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low suspends the next cycle and holds self refresh |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write strobe |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address, column address and bit-10 option |
| cmd_valid | output | 1 | Accepted-command pulse |
| cmd_code | output | 3 | Strobe code of the accepted command |
| cmd_bank | output | 2 | Bank of the accepted command |
| cmd_row | output | 13 | Row for activate, read and write; mode value for mode set |
| cmd_col | output | 9 | Column for read and write |
| auto_pre | output | 1 | Read or write carries auto precharge |
| all_banks | output | 1 | Precharge applies to every bank |
| self_ref | output | 1 | Self refresh in progress |
| illegal | output | 1 | Command rejected by the bank rules |

## Verification
Every result register updates at the edge that samples the command, so each outcome is visible one edge after the stimulus. Clock-enable suspension takes effect one edge later still, and the auto-precharge release arrives exactly AP_DELAY edges after the access. The bench drives inputs on the falling edge and compares all outputs at the next falling edge, so each comparison sees the result of exactly one rising edge. The delayed effects are placed as separate table rows at the edge where they are due, on both sides of the AP_DELAY boundary.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  // Command codes equal the sampled {ras_n, cas_n, we_n} bits.
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;  // deselect overrides the strobes (R1)
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int AP_DELAY = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           act_en,
  input  logic                           rw_en,
  input  logic                           pre_en,
  input  logic                           pre_all,
  input  logic                           ap,
  input  logic [BA_W-1:0]                bank,
  input  logic [ROW_W-1:0]               row_in,
  output logic [(1<<BA_W)-1:0]           act_ok,
  output logic [(1<<BA_W)-1:0]           rw_ok,
  output logic [(1<<BA_W)-1:0][ROW_W-1:0] open_row
);
  localparam int NBANK = 1 << BA_W;
  localparam int CW    = $clog2(AP_DELAY + 1);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CW-1:0]    cnt_q;
    logic             hit;
    logic             due;

    assign hit         = (bank == BA_W'(g));
    assign due         = (cnt_q == CW'(1));
    assign act_ok[g]   = !open_q || due;
    assign rw_ok[g]    = open_q && (cnt_q == '0);
    assign open_row[g] = row_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q <= 1'b0;
        row_q  <= '0;
        cnt_q  <= '0;
      end else begin
        if (due) begin
          open_q <= 1'b0;
          cnt_q  <= '0;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end
        if (pre_en && (pre_all || hit)) begin
          open_q <= 1'b0;
          cnt_q  <= '0;
        end
        if (act_en && hit) begin
          open_q <= 1'b1;
          row_q  <= row_in;
          cnt_q  <= '0;
        end
        if (rw_en && ap && hit) begin
          cnt_q <= CW'(AP_DELAY);
        end
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int AP_BIT   = 10,
  parameter int AP_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             auto_pre,
  output logic             all_banks,
  output logic             self_ref,
  output logic             illegal
);
  localparam int NBANK = 1 << BA_W;

  cmd_e                        cmd;
  logic                        cke_q;
  logic                        sref_q;
  logic                        accept;
  logic                        legal;
  logic                        go;
  logic                        is_rw;
  logic [NBANK-1:0]            act_ok;
  logic [NBANK-1:0]            rw_ok;
  logic [NBANK-1:0][ROW_W-1:0] open_row;

  ddr_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  assign accept = !sref_q && cke_q && (cmd != CMD_NOP);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    case (cmd)
      CMD_ACT:        legal = act_ok[ba];
      CMD_RD, CMD_WR: legal = rw_ok[ba];
      default:        legal = 1'b1;
    endcase
  end

  assign go = accept && legal;

  ddr_bank_track #(
    .BA_W    (BA_W),
    .ROW_W   (ROW_W),
    .AP_DELAY(AP_DELAY)
  ) u_banks (
    .clk     (clk),
    .rst     (rst),
    .act_en  (go && (cmd == CMD_ACT)),
    .rw_en   (go && is_rw),
    .pre_en  (go && (cmd == CMD_PRE)),
    .pre_all (addr[AP_BIT]),
    .ap      (addr[AP_BIT]),
    .bank    (ba),
    .row_in  (addr),
    .act_ok  (act_ok),
    .rw_ok   (rw_ok),
    .open_row(open_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q     <= 1'b1;
      sref_q    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      auto_pre  <= 1'b0;
      all_banks <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      cke_q <= cke;
      if (sref_q) begin
        if (cke) sref_q <= 1'b0;
      end else if (go && (cmd == CMD_REF) && !cke) begin
        sref_q <= 1'b1;
      end
      cmd_valid <= go;
      illegal   <= accept && !legal;
      cmd_code  <= go ? 3'(cmd) : 3'b000;
      cmd_bank  <= go ? ba : '0;
      if (go && ((cmd == CMD_ACT) || (cmd == CMD_MRS))) cmd_row <= addr;
      else if (go && is_rw)                             cmd_row <= open_row[ba];
      else                                              cmd_row <= '0;
      cmd_col   <= (go && is_rw) ? addr[COL_W-1:0] : '0;
      auto_pre  <= go && is_rw && addr[AP_BIT];
      all_banks <= go && (cmd == CMD_PRE) && addr[AP_BIT];
    end
  end

  assign self_ref = sref_q;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       auto_pre,
  input logic       all_banks,
  input logic       self_ref,
  input logic       illegal
);
  p_cs_nop_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!cmd_valid && !illegal));

  p_code_known_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_code != 3'b111) && (cmd_code != 3'b110));

  p_ap_rw_r5: assert property (@(posedge clk) disable iff (rst)
    auto_pre |-> cmd_valid && ((cmd_code == 3'b101) || (cmd_code == 3'b100)));

  p_all_pre_r6: assert property (@(posedge clk) disable iff (rst)
    all_banks |-> cmd_valid && (cmd_code == 3'b010));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && illegal));

  p_suspend_r8: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ##2 (!cmd_valid && !illegal));

  p_sref_entry_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(self_ref) |-> cmd_valid && (cmd_code == 3'b001));

  p_sref_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    self_ref |=> (!cmd_valid && !illegal));

  p_sref_exit_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(self_ref) && !$past(rst)) |-> $past(cke));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cke      (cke),
  .cs_n     (cs_n),
  .cmd_valid(cmd_valid),
  .cmd_code (cmd_code),
  .auto_pre (auto_pre),
  .all_banks(all_banks),
  .self_ref (self_ref),
  .illegal  (illegal)
);

// File: tb/tb_ddr_cmd_tracker.sv
module tb_ddr_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  typedef struct packed {
    logic        cke;
    logic        cs_n;
    logic [2:0]  c;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        v;
    logic        ill;
    logic [2:0]  code;
    logic [1:0]  bk;
    logic [12:0] row;
    logic [8:0]  col;
    logic        ap;
    logic        al;
    logic        sr;
    logic [3:0]  req;
  } vec_t;

  // AP_DELAY = 4 assumed by rows 7..11
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,3'd7,2'd0,13'h0000, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd2},  // R2 nop
    '{1'b1,1'b0,3'd3,2'd0,13'h1ABC, 1'b1,1'b0,3'd3,2'd0,13'h1ABC,9'h000,1'b0,1'b0,1'b0,4'd3},  // R3 act b0
    '{1'b1,1'b0,3'd3,2'd0,13'h0005, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd7},  // R7 act open
    '{1'b1,1'b0,3'd5,2'd0,13'h0123, 1'b1,1'b0,3'd5,2'd0,13'h1ABC,9'h123,1'b0,1'b0,1'b0,4'd4},  // R4 rd b0
    '{1'b1,1'b1,3'd3,2'd1,13'h0001, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd1},  // R1 deselect
    '{1'b1,1'b0,3'd5,2'd1,13'h0000, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd4},  // R4 rd closed
    '{1'b1,1'b0,3'd3,2'd1,13'h0777, 1'b1,1'b0,3'd3,2'd1,13'h0777,9'h000,1'b0,1'b0,1'b0,4'd3},  // R3 act b1
    '{1'b1,1'b0,3'd4,2'd1,13'h05FF, 1'b1,1'b0,3'd4,2'd1,13'h0777,9'h1FF,1'b1,1'b0,1'b0,4'd5},  // R5 wr ap, edge N
    '{1'b1,1'b0,3'd5,2'd1,13'h0000, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd5},  // R5 N+1 rd
    '{1'b1,1'b0,3'd3,2'd1,13'h0001, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd5},  // R5 N+2 act
    '{1'b1,1'b0,3'd7,2'd0,13'h0000, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd5},  // R5 N+3
    '{1'b1,1'b0,3'd3,2'd1,13'h0042, 1'b1,1'b0,3'd3,2'd1,13'h0042,9'h000,1'b0,1'b0,1'b0,4'd5},  // R5 N+4 act ok
    '{1'b1,1'b0,3'd2,2'd0,13'h0000, 1'b1,1'b0,3'd2,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd6},  // R6 pre b0
    '{1'b1,1'b0,3'd5,2'd0,13'h0000, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd6},  // R6 b0 closed
    '{1'b1,1'b0,3'd5,2'd1,13'h0000, 1'b1,1'b0,3'd5,2'd1,13'h0042,9'h000,1'b0,1'b0,1'b0,4'd6},  // R6 b1 kept
    '{1'b1,1'b0,3'd2,2'd2,13'h0400, 1'b1,1'b0,3'd2,2'd2,13'h0000,9'h000,1'b0,1'b1,1'b0,4'd6},  // R6 pre all
    '{1'b1,1'b0,3'd5,2'd1,13'h0000, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd6},  // R6 b1 closed
    '{1'b1,1'b0,3'd0,2'd0,13'h0033, 1'b1,1'b0,3'd0,2'd0,13'h0033,9'h000,1'b0,1'b0,1'b0,4'd2},  // R2 mode set
    '{1'b1,1'b0,3'd1,2'd0,13'h0000, 1'b1,1'b0,3'd1,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd2},  // R2 auto refresh
    '{1'b0,1'b0,3'd7,2'd0,13'h0000, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd8},  // R8 cke low
    '{1'b1,1'b0,3'd3,2'd2,13'h0009, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd8},  // R8 suspended
    '{1'b1,1'b0,3'd3,2'd2,13'h0009, 1'b1,1'b0,3'd3,2'd2,13'h0009,9'h000,1'b0,1'b0,1'b0,4'd8},  // R8 b2 was closed
    '{1'b0,1'b0,3'd1,2'd0,13'h0000, 1'b1,1'b0,3'd1,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b1,4'd9},  // R9 sref entry
    '{1'b0,1'b0,3'd3,2'd3,13'h0003, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b1,4'd10}, // R10 held
    '{1'b0,1'b0,3'd7,2'd0,13'h0000, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b1,4'd10}, // R10 held
    '{1'b1,1'b0,3'd3,2'd3,13'h0003, 1'b0,1'b0,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd10}, // R10 exit edge
    '{1'b1,1'b0,3'd3,2'd3,13'h0003, 1'b1,1'b0,3'd3,2'd3,13'h0003,9'h000,1'b0,1'b0,1'b0,4'd3},  // R3 b3 was closed
    '{1'b1,1'b0,3'd3,2'd3,13'h0004, 1'b0,1'b1,3'd0,2'd0,13'h0000,9'h000,1'b0,1'b0,1'b0,4'd7}   // R7 act open
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        cmd_valid, auto_pre, all_banks, self_ref, illegal;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [8:0]  cmd_col;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ddr_cmd_tracker dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .auto_pre(auto_pre),
    .all_banks(all_banks), .self_ref(self_ref), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] outs();
    return {cmd_valid, illegal, cmd_code, cmd_bank, cmd_row, cmd_col, auto_pre, all_banks, self_ref};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic k, logic cs, logic [2:0] c, logic [1:0] b, logic [12:0] a);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset outputs", outs(), 32'h0);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cke, VECS[i].cs_n, VECS[i].c, VECS[i].ba, VECS[i].addr);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VECS[i].req, i), outs(),
            {VECS[i].v, VECS[i].ill, VECS[i].code, VECS[i].bk, VECS[i].row,
             VECS[i].col, VECS[i].ap, VECS[i].al, VECS[i].sr});
    end
    // R11: reset with banks 2 and 3 open closes them
    rst = 1'b1; drive(1'b1, 1'b0, 3'd7, 2'd0, 13'h0);
    @(negedge clk);
    check("R11 outputs in reset", outs(), 32'h0);
    rst = 1'b0; drive(1'b1, 1'b0, 3'd5, 2'd3, 13'h0);
    @(negedge clk);
    check("R11 bank closed by reset", {cmd_valid, illegal}, 32'h1);
    // R9 entry again, then R11 reset leaves self refresh
    drive(1'b0, 1'b0, 3'd1, 2'd0, 13'h0);
    @(negedge clk);
    check("R9 self_ref set", self_ref, 32'h1);
    rst = 1'b1; drive(1'b0, 1'b0, 3'd7, 2'd0, 13'h0);
    @(negedge clk);
    check("R11 self_ref cleared", self_ref, 32'h0);
    rst = 1'b0; drive(1'b1, 1'b0, 3'd3, 2'd0, 13'h0011);
    @(negedge clk);
    check("R11 first edge not suspended", {cmd_valid, illegal, cmd_row}, {2'b10, 13'h0011});
    drive(1'b1, 1'b0, 3'd6, 2'd0, 13'h0);
    @(negedge clk);
    check("R2 code 110 is nop", {cmd_valid, illegal}, 32'h0);
    finish_run();
  end
endmodule